// File: doc/BRIEF.md
# Triggered Serial Probe Monitor

This block lets software watch four internal values on one pin. Software loads four probe registers, indexed 0 to 3, through a simple write port. A one-cycle start pulse from the compute engine marks that a computation pass is about to begin. On that pulse the block copies all four probes into a shadow register and shifts them out serially. A receiver outside the chip can then capture a snapshot of the probes ahead of every pass.

Each frame begins with one high marker bit. Forty data bits follow: probe 0 first and probe 3 last, each probe with its most significant bit first. A bit-clock enable input sets the pace. A busy output stays high while a frame is in flight. An enable input gates the whole function. While enable is low, the pin stays low, no frame starts, and a frame already running stops at once.

Top module: `probe_serial_monitor`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` into probe register `wr_sel` (0 to 3) on that clock edge. The stored value is the one the next frame sends.
- R2: A `trigger` pulse sampled while `enable` is high and `busy` is low starts a frame. On the following cycle `pin_out` is 1 (the marker bit) and `busy` is 1.
- R3: During a frame, each sampled `bit_tick` moves the pin to the next data bit one cycle later. The order is the 40-bit word {probe0, probe1, probe2, probe3}, sent from bit 39 down to bit 0. While no frame is running, `bit_tick` has no effect.
- R4: The tick after the last data bit (the 41st tick after the trigger) drives `pin_out` low and clears `busy` on the next cycle.
- R5: A frame sends the probe values held at the trigger edge. Writes made during a frame change only later frames.
- R6: A `trigger` sampled while `busy` is high is ignored. The running frame continues unchanged.
- R7: `busy` stays high from the marker bit through the last data bit, and `pin_out` is never high while `busy` is low.
- R8: While `enable` is low, `pin_out` and `busy` are 0 one cycle later and triggers are ignored. Clearing `enable` mid-frame aborts the frame.
- R9: Synchronous reset clears `pin_out`, `busy` and all four probe registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Master enable for the monitor output |
| wr_en | input | 1 | Probe register write strobe |
| wr_sel | input | 2 | Index of the probe register to write |
| wr_data | input | 10 | Probe register write value |
| trigger | input | 1 | Pass-start pulse that requests a frame |
| bit_tick | input | 1 | Bit-clock enable that advances the frame |
| pin_out | output | 1 | Serial monitor pin |
| busy | output | 1 | High while a frame is being sent |

## Verification
The bench sends frames built from several arithmetic patterns at two bit rates and checks every bit, including the idle cycles between ticks. A design with the wrong probe order, the wrong bit order, or an off-by-one end would send a wrong bit or drop `busy` at the wrong tick. Software writes in the middle of a frame test the shadow copy. Without it, a frame would send the new values partway through. A repeated trigger in the middle of a frame tests R6. A design that restarts on it would send the marker bit again. Clearing enable in the middle of a frame, and pulsing the trigger while disabled, tests that the pin falls at once and that no frame starts.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int PM_PROBE_W    = 10;
  localparam int PM_NUM_PROBES = 4;

  typedef struct packed {
    logic load;    // capture probes, emit marker bit
    logic adv;     // advance one bit
    logic finish;  // this advance ends the frame
  } pm_step_t;
endpackage

// File: rtl/pm_probe_bank.sv
module pm_probe_bank #(
  parameter int PROBE_W    = 10,
  parameter int NUM_PROBES = 4,
  localparam int SEL_W     = (NUM_PROBES > 1) ? $clog2(NUM_PROBES) : 1,
  localparam int FLAT_W    = PROBE_W * NUM_PROBES
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [SEL_W-1:0]   wr_sel,
  input  logic [PROBE_W-1:0] wr_data,
  output logic [FLAT_W-1:0]  probes_flat
);
  logic [PROBE_W-1:0] regs [NUM_PROBES];

  for (genvar i = 0; i < NUM_PROBES; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) regs[i] <= '0;
      else if (wr_en && (wr_sel == SEL_W'(i))) regs[i] <= wr_data;
    end
    // probe 0 occupies the most significant slice so it leaves first
    assign probes_flat[FLAT_W-1-i*PROBE_W -: PROBE_W] = regs[i];

    a_r1_write_lands: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_sel == SEL_W'(i)) |=> (regs[i] == $past(wr_data)));
  end
endmodule

// File: rtl/pm_frame_ctrl.sv
module pm_frame_ctrl
  import pm_pkg::*;
#(
  parameter int FRAME_BITS = 40,
  localparam int CNT_W     = $clog2(FRAME_BITS + 1)
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     enable,
  input  logic     trigger,
  input  logic     bit_tick,
  output pm_step_t step,
  output logic     busy
);
  logic [CNT_W-1:0] cnt;

  always_comb begin
    step.load   = enable && trigger && !busy;
    step.adv    = enable && busy && bit_tick;
    step.finish = step.adv && (cnt == CNT_W'(FRAME_BITS));
  end

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (step.load) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (step.finish) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (step.adv) begin
      cnt  <= cnt + 1'b1;
    end
  end

  a_r8_abort_clears_busy: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !busy);
  a_r6_busy_held: assert property (@(posedge clk) disable iff (rst)
    (busy && enable && !bit_tick) |=> busy);
  a_r4_frame_ends: assert property (@(posedge clk) disable iff (rst)
    step.finish |=> (!busy && cnt == '0));
  a_r3_count_bounded: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt <= CNT_W'(FRAME_BITS)));
endmodule

// File: rtl/pm_shift_out.sv
module pm_shift_out
  import pm_pkg::*;
#(
  parameter int FRAME_BITS = 40
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  enable,
  input  pm_step_t              step,
  input  logic [FRAME_BITS-1:0] probes_flat,
  output logic                  pin_out
);
  logic [FRAME_BITS-1:0] shadow;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow  <= '0;
      pin_out <= 1'b0;
    end else if (!enable) begin
      pin_out <= 1'b0;
    end else if (step.load) begin
      shadow  <= probes_flat;
      pin_out <= 1'b1;
    end else if (step.finish) begin
      pin_out <= 1'b0;
    end else if (step.adv) begin
      pin_out <= shadow[FRAME_BITS-1];
      shadow  <= {shadow[FRAME_BITS-2:0], 1'b0};
    end
  end

  a_r2_marker_bit: assert property (@(posedge clk) disable iff (rst)
    step.load |=> pin_out);
  a_r8_pin_low_off: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !pin_out);
  a_r5_shadow_stable: assert property (@(posedge clk) disable iff (rst)
    (enable && !step.load && !step.adv) |=> $stable(shadow));
endmodule

// File: rtl/probe_serial_monitor.sv
module probe_serial_monitor
  import pm_pkg::*;
#(
  parameter int PROBE_W    = PM_PROBE_W,
  parameter int NUM_PROBES = PM_NUM_PROBES,
  localparam int SEL_W     = (NUM_PROBES > 1) ? $clog2(NUM_PROBES) : 1,
  localparam int FRAME_BITS = PROBE_W * NUM_PROBES
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic               wr_en,
  input  logic [SEL_W-1:0]   wr_sel,
  input  logic [PROBE_W-1:0] wr_data,
  input  logic               trigger,
  input  logic               bit_tick,
  output logic               pin_out,
  output logic               busy
);
  logic [FRAME_BITS-1:0] probes_flat;
  pm_step_t              step;

  pm_probe_bank #(.PROBE_W(PROBE_W), .NUM_PROBES(NUM_PROBES)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .probes_flat(probes_flat)
  );

  pm_frame_ctrl #(.FRAME_BITS(FRAME_BITS)) u_ctrl (
    .clk(clk), .rst(rst), .enable(enable), .trigger(trigger),
    .bit_tick(bit_tick), .step(step), .busy(busy)
  );

  pm_shift_out #(.FRAME_BITS(FRAME_BITS)) u_shift (
    .clk(clk), .rst(rst), .enable(enable), .step(step),
    .probes_flat(probes_flat), .pin_out(pin_out)
  );

  a_r7_pin_inside_frame: assert property (@(posedge clk) disable iff (rst)
    pin_out |-> busy);
endmodule

// File: tb/probe_serial_monitor_tb.sv
module probe_serial_monitor_tb;
  logic clk = 1'b0;
  logic rst, enable, wr_en, trigger, bit_tick;
  logic [1:0] wr_sel;
  logic [9:0] wr_data;
  logic pin_out, busy;
  int   n_run = 0, n_fail = 0;
  bit   done = 1'b0;
  logic [9:0] probe_m [4];

  always #2 clk = ~clk;

  probe_serial_monitor u_dut (
    .clk(clk), .rst(rst), .enable(enable), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .trigger(trigger), .bit_tick(bit_tick),
    .pin_out(pin_out), .busy(busy)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    wr_en = 0; trigger = 0; bit_tick = 0;
  endtask

  task automatic write_probe(input int idx, input logic [9:0] val);
    wr_en = 1; wr_sel = idx[1:0]; wr_data = val;
    @(negedge clk);
    idle_inputs();
    probe_m[idx] = val;
  endtask

  // runs one frame; -1 disables the optional events
  task automatic run_frame(input int div, input int retrig_k, input int wr_k,
                           input int abort_k);
    logic [39:0] efr;
    logic prev;
    efr = {probe_m[0], probe_m[1], probe_m[2], probe_m[3]};
    trigger = 1;
    @(negedge clk);
    idle_inputs();
    check("R2 marker", pin_out, 1);
    check("R2 busy", busy, 1);
    prev = 1'b1;
    for (int k = 0; k <= 40; k++) begin
      for (int d = 1; d < div; d++) begin
        @(negedge clk);
        check("R3 hold", pin_out, prev);
        check("R7 busy", busy, 1);
      end
      if (k == abort_k) begin
        enable = 0; bit_tick = 1;
        @(negedge clk);
        idle_inputs();
        check("R8 abort pin", pin_out, 0);
        check("R8 abort busy", busy, 0);
        trigger = 1;
        @(negedge clk);
        idle_inputs();
        check("R8 trig ignored pin", pin_out, 0);
        check("R8 trig ignored busy", busy, 0);
        enable = 1;
        @(negedge clk);
        return;
      end
      if (k == wr_k) begin
        wr_en = 1; wr_sel = k[1:0]; wr_data = ~probe_m[k % 4];
      end
      if (k == retrig_k) trigger = 1;
      bit_tick = 1;
      @(negedge clk);
      if (k == wr_k) probe_m[k % 4] = ~probe_m[k % 4];
      idle_inputs();
      if (k < 40) begin
        prev = efr[39-k];
        check(k == retrig_k ? "R6 retrigger" : (k == wr_k ? "R5 shadow" : "R3 bit"),
              pin_out, prev);
        check("R7 busy", busy, 1);
      end else begin
        check("R4 end pin", pin_out, 0);
        check("R4 end busy", busy, 0);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1; enable = 1; wr_sel = 0; wr_data = 0;
    idle_inputs();
    for (int i = 0; i < 4; i++) probe_m[i] = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R9 reset pin", pin_out, 0);
    check("R9 reset busy", busy, 0);
    // idle ticks do nothing
    bit_tick = 1;
    repeat (3) @(negedge clk);
    idle_inputs();
    check("R3 idle tick", pin_out, 0);
    // frame of reset contents: all zero (R9)
    run_frame(1, -1, -1, -1);
    // pattern sweep at two bit rates (R1, R3, R4)
    for (int p = 0; p < 8; p++) begin
      for (int i = 0; i < 4; i++)
        write_probe(i, 10'((p * 293 + i * 181 + (p << i)) ^ (i == p % 4 ? 10'h3FF : 10'h0)));
      run_frame((p % 2) + 1, -1, -1, -1);
    end
    // back-to-back trigger right after a frame ends
    run_frame(1, -1, -1, -1);
    // write mid-frame then send again (R5, R1)
    write_probe(0, 10'h2AA); write_probe(1, 10'h155);
    write_probe(2, 10'h3C3); write_probe(3, 10'h01F);
    run_frame(2, -1, 6, -1);
    run_frame(1, -1, -1, -1);
    // retrigger inside a frame (R6)
    run_frame(2, 3, -1, -1);
    run_frame(1, 17, -1, -1);
    // abort mid-frame then recover (R8)
    run_frame(2, -1, -1, 12);
    run_frame(1, -1, -1, -1);
    // trigger while disabled (R8)
    enable = 0;
    @(negedge clk);
    trigger = 1;
    @(negedge clk);
    idle_inputs();
    check("R8 disabled pin", pin_out, 0);
    check("R8 disabled busy", busy, 0);
    enable = 1;
    repeat (2) @(negedge clk);
    check("R8 no late frame", pin_out, 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule